// File: doc/BRIEF.md
# Parallel Full-Search Scheduler and Selector

This block sequences an exhaustive integer motion search in which eight SAD groups run side by side over a 32 by 32 candidate range. The range is cut into vertical strips four candidates wide, one strip per group. Every group walks its strip one column at a time. For each candidate it spends sixteen cycles, and in each of those cycles the block names one row of the current 16x16 block and the matching row of the 48x48 reference window. All groups share one row counter. Each group gets its own column base and its own signed horizontal motion vector tag. A pulse marks the last row of each candidate, so that the external SAD trees know when to fold the candidate into their local minima.

When the scan of 2048 cycles ends, a selection phase visits the local minimum store of every group for each of the 41 partitions. It reads one group and one partition per cycle, with the partition as the outer loop. After the eighth group of a partition it writes out the global minimum SAD for that partition and the motion vector of the group that owns it. A `busy` flag covers the whole operation. A one-cycle `done` pulse marks the end.

Top module: `fs_sched_select`

## Requirements
- R1: After reset, `busy`, `done`, `scan_valid`, `pos_done` and `res_valid` are all 0.
- R2: A `start` sampled while idle begins the scan: in the next cycle `scan_valid` is 1, `cur_row` is 0 and `ref_row` is 0. A `start` sampled while `busy` is 1 has no effect.
- R3: In scan cycle t (t = 0 in the first scan cycle), `cur_row` equals t mod 16 and `ref_row` equals p + (t mod 16), where p = (t div 16) mod 32.
- R4: In scan cycle t, the column base for group k (bits 6k+5..6k of `ref_col`) equals 4k + c, where c = t div 512.
- R5: `pos_done` is 1 exactly in the scan cycles with t mod 16 = 15. The motion vector tag for group k (bits 6k+5..6k of `pos_mvx`, 6-bit two's complement) equals 4k + c - 16, and `pos_mvy` equals p - 16. Both lie in the range -16 to +15.
- R6: The scan lasts exactly 2048 cycles. Then `scan_valid` falls and selection runs. `sel_part` steps from 0 to 40 and, for each partition, `sel_grp` steps from 0 to 7, one pair per cycle.
- R7: One cycle after the cycle in which `sel_grp` is 7, `res_valid` is 1 for that cycle only. In that cycle `res_part` is the partition, `res_sad` is the smallest `loc_sad` seen across the eight groups, and `res_mvx`/`res_mvy` are the vector read with it. On equal SADs the lower group index wins.
- R8: `busy` stays 1 from the first scan cycle to the last selection cycle. It falls in the same cycle as the final result, and `done` is 1 for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search when idle |
| busy | output | 1 | Search or selection in progress |
| done | output | 1 | One-cycle end pulse |
| scan_valid | output | 1 | Scan phase active |
| cur_row | output | 4 | Row of the current block |
| ref_row | output | 6 | Row of the reference window |
| ref_col | output | 48 | Per-group reference column base, 6 bits per group |
| pos_done | output | 1 | Last row of the current candidate |
| pos_mvx | output | 48 | Per-group signed horizontal vector tag, 6 bits per group |
| pos_mvy | output | 6 | Signed vertical vector tag |
| sel_grp | output | 3 | Group addressed during selection |
| sel_part | output | 6 | Partition addressed during selection |
| loc_sad | input | 16 | Local minimum SAD of the addressed group and partition |
| loc_mvx | input | 6 | Its horizontal vector |
| loc_mvy | input | 6 | Its vertical vector |
| res_valid | output | 1 | Global result strobe |
| res_part | output | 6 | Partition of the result |
| res_sad | output | 16 | Global minimum SAD |
| res_mvx | output | 6 | Vector x of the winner |
| res_mvy | output | 6 | Vector y of the winner |

## Verification
All scan addressing comes from a single position counter. An off-by-one in that counter therefore shows up at once, in the same cycle, on `cur_row` and `ref_row`. The column bases and vector tags go wrong at the 512-cycle column boundaries. A slip in the selection counters shows up in `sel_grp`/`sel_part` as soon as they are read. A running minimum that keeps the wrong operand, or that lets a later group win a tie, only becomes visible at the next `res_valid`, which is at most eight cycles later. The loaded SAD patterns make ties across groups that carry different vectors, so a broken tie-break is reported. Any error in the phase lengths moves the fall of `scan_valid`, the fall of `busy` or the `done` pulse by whole cycles.

// File: rtl/fs_sched_select.sv
module fs_sched_select #(
  parameter int GROUPS  = 8,
  parameter int RANGE_W = 32,
  parameter int RANGE_H = 32,
  parameter int BLK     = 16,
  parameter int PARTS   = 41,
  parameter int SADW    = 16,
  parameter int WINW    = 6,
  parameter int XW      = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   scan_valid,
  output logic [$clog2(BLK)-1:0] cur_row,
  output logic [WINW-1:0]        ref_row,
  output logic [GROUPS*WINW-1:0] ref_col,
  output logic                   pos_done,
  output logic [GROUPS*XW-1:0]   pos_mvx,
  output logic [XW-1:0]          pos_mvy,
  output logic [$clog2(GROUPS)-1:0] sel_grp,
  output logic [$clog2(PARTS)-1:0]  sel_part,
  input  logic [SADW-1:0]        loc_sad,
  input  logic [XW-1:0]          loc_mvx,
  input  logic [XW-1:0]          loc_mvy,
  output logic                   res_valid,
  output logic [$clog2(PARTS)-1:0] res_part,
  output logic [SADW-1:0]        res_sad,
  output logic [XW-1:0]          res_mvx,
  output logic [XW-1:0]          res_mvy
);
  localparam int STRIP    = RANGE_W / GROUPS;
  localparam int ROWW     = $clog2(BLK);
  localparam int PW       = $clog2(RANGE_H);
  localparam int CW       = (STRIP > 1) ? $clog2(STRIP) : 1;
  localparam int CNTW     = ROWW + PW + CW;
  localparam int SCAN_CYC = BLK * RANGE_H * STRIP;
  localparam int GW       = $clog2(GROUPS);
  localparam int JW       = $clog2(PARTS);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_SEL} st_t;

  st_t             st;
  logic [CNTW-1:0] cnt;
  logic [GW-1:0]   g;
  logic [JW-1:0]   j;
  logic [SADW-1:0] best_sad;
  logic [XW-1:0]   best_x, best_y;

  logic [ROWW-1:0] r;
  logic [PW-1:0]   p;
  logic [CW-1:0]   c;
  logic            take;
  logic [SADW-1:0] nx_sad;
  logic [XW-1:0]   nx_x, nx_y;

  assign r = cnt[ROWW-1:0];
  assign p = cnt[ROWW +: PW];
  assign c = cnt[ROWW+PW +: CW];

  assign busy       = (st != S_IDLE);
  assign scan_valid = (st == S_SCAN);
  assign cur_row    = r;
  assign ref_row    = WINW'(p) + WINW'(r);
  assign pos_done   = scan_valid && (r == ROWW'(BLK-1));
  assign pos_mvy    = XW'(p) - XW'(RANGE_H/2);
  assign sel_grp    = g;
  assign sel_part   = j;

  for (genvar k = 0; k < GROUPS; k++) begin : g_strip
    assign ref_col[k*WINW +: WINW] = WINW'(k*STRIP) + WINW'(c);
    assign pos_mvx[k*XW +: XW]     = XW'(k*STRIP) + XW'(c) - XW'(RANGE_W/2);
  end

  assign take   = (g == '0) || (loc_sad < best_sad);
  assign nx_sad = take ? loc_sad : best_sad;
  assign nx_x   = take ? loc_mvx : best_x;
  assign nx_y   = take ? loc_mvy : best_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      g         <= '0;
      j         <= '0;
      best_sad  <= '0;
      best_x    <= '0;
      best_y    <= '0;
      res_valid <= 1'b0;
      done      <= 1'b0;
      res_part  <= '0;
      res_sad   <= '0;
      res_mvx   <= '0;
      res_mvy   <= '0;
    end else begin
      res_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_SCAN;
          cnt <= '0;
        end
        S_SCAN: if (cnt == CNTW'(SCAN_CYC-1)) begin
          st <= S_SEL;
          g  <= '0;
          j  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_SEL: begin
          best_sad <= nx_sad;
          best_x   <= nx_x;
          best_y   <= nx_y;
          if (g == GW'(GROUPS-1)) begin
            res_valid <= 1'b1;
            res_part  <= j;
            res_sad   <= nx_sad;
            res_mvx   <= nx_x;
            res_mvy   <= nx_y;
            g         <= '0;
            if (j == JW'(PARTS-1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              j <= j + 1'b1;
            end
          end else begin
            g <= g + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fs_sched_select_chk.sv
module fs_sched_select_chk #(
  parameter int GROUPS = 8,
  parameter int BLK    = 16,
  parameter int PARTS  = 41
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      busy,
  input logic                      done,
  input logic                      scan_valid,
  input logic [$clog2(BLK)-1:0]    cur_row,
  input logic                      pos_done,
  input logic [$clog2(GROUPS)-1:0] sel_grp,
  input logic [$clog2(PARTS)-1:0]  sel_part,
  input logic                      res_valid
);
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (scan_valid && cur_row == '0));

  p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && cur_row != '1) |=> (scan_valid && cur_row == $past(cur_row) + 1'b1));

  p_pos_last_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_done |-> (scan_valid && cur_row == '1));

  p_sel_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_valid) |-> (busy && sel_grp == '0 && sel_part == '0));

  p_res_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(sel_grp) == $clog2(GROUPS)'(GROUPS-1)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && res_valid));
endmodule

bind fs_sched_select fs_sched_select_chk #(
  .GROUPS(GROUPS), .BLK(BLK), .PARTS(PARTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .scan_valid(scan_valid), .cur_row(cur_row), .pos_done(pos_done),
  .sel_grp(sel_grp), .sel_part(sel_part), .res_valid(res_valid)
);

// File: tb/fs_sched_select_tb.sv
`timescale 1ns/1ps
module fs_sched_select_tb;
  logic        clk = 1'b0;
  logic        rst_n, start;
  logic        busy, done, scan_valid, pos_done, res_valid;
  logic [3:0]  cur_row;
  logic [5:0]  ref_row, pos_mvy, res_mvx, res_mvy, loc_mvx, loc_mvy, sel_part, res_part;
  logic [47:0] ref_col, pos_mvx;
  logic [2:0]  sel_grp;
  logic [15:0] loc_sad, res_sad;

  int checks = 0, fails = 0, seed = 0;
  int mstate = 0, mcnt = 0, mg = 0, mj = 0;
  int erv = 0, edone = 0, epart = 0, esad = 0, emx = 0, emy = 0;

  always #2.5 clk = ~clk;

  fs_sched_select u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .scan_valid(scan_valid), .cur_row(cur_row), .ref_row(ref_row),
    .ref_col(ref_col), .pos_done(pos_done), .pos_mvx(pos_mvx), .pos_mvy(pos_mvy),
    .sel_grp(sel_grp), .sel_part(sel_part), .loc_sad(loc_sad),
    .loc_mvx(loc_mvx), .loc_mvy(loc_mvy), .res_valid(res_valid),
    .res_part(res_part), .res_sad(res_sad), .res_mvx(res_mvx), .res_mvy(res_mvy)
  );

  function automatic int f_sad(int g, int j, int s);
    return ((g*3 + j + s*2) % 5) * 100 + ((j*7 + s) % 50);
  endfunction
  function automatic int f_mvx(int g, int j);
    return g*4 - 16 + (j % 4);
  endfunction
  function automatic int f_mvy(int j, int s);
    return ((j + s) % 32) - 16;
  endfunction

  always_comb begin
    loc_sad = 16'(f_sad(int'(sel_grp), int'(sel_part), seed));
    loc_mvx = 6'(f_mvx(int'(sel_grp), int'(sel_part)));
    loc_mvy = 6'(f_mvy(int'(sel_part), seed));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int r, p, c;
    chk(busy == (mstate != 0), "R8 busy", busy, mstate != 0);
    chk(scan_valid == (mstate == 1), "R6 scan_valid", scan_valid, mstate == 1);
    chk(res_valid == erv, "R7 res_valid", res_valid, erv);
    chk(done == edone, "R8 done", done, edone);
    if (mstate == 1) begin
      r = mcnt % 16; p = (mcnt / 16) % 32; c = mcnt / 512;
      chk(int'(cur_row) == r, "R3 cur_row", cur_row, r);
      chk(int'(ref_row) == p + r, "R3 ref_row", ref_row, p + r);
      chk(pos_done == (r == 15), "R5 pos_done", pos_done, r == 15);
      chk(int'($signed(pos_mvy)) == p - 16, "R5 pos_mvy", $signed(pos_mvy), p - 16);
      for (int k = 0; k < 8; k++) begin
        chk(int'(ref_col[k*6 +: 6]) == 4*k + c, "R4 ref_col", ref_col[k*6 +: 6], 4*k + c);
        chk(int'($signed(pos_mvx[k*6 +: 6])) == 4*k + c - 16, "R5 pos_mvx",
            $signed(pos_mvx[k*6 +: 6]), 4*k + c - 16);
      end
    end else begin
      chk(pos_done == 1'b0, "R5 pos_done idle", pos_done, 0);
    end
    if (mstate == 2) begin
      chk(int'(sel_grp) == mg, "R6 sel_grp", sel_grp, mg);
      chk(int'(sel_part) == mj, "R6 sel_part", sel_part, mj);
    end
    if (erv != 0) begin
      chk(int'(res_part) == epart, "R7 res_part", res_part, epart);
      chk(int'(res_sad) == esad, "R7 res_sad", res_sad, esad);
      chk(int'($signed(res_mvx)) == emx, "R7 res_mvx tie-break", $signed(res_mvx), emx);
      chk(int'($signed(res_mvy)) == emy, "R7 res_mvy", $signed(res_mvy), emy);
    end
  endtask

  task automatic advance(input bit s);
    int bs, bg;
    erv = 0; edone = 0;
    case (mstate)
      0: if (s) begin mstate = 1; mcnt = 0; end
      1: if (mcnt == 2047) begin mstate = 2; mg = 0; mj = 0; end
         else mcnt++;
      default: if (mg == 7) begin
        bs = f_sad(0, mj, seed); bg = 0;
        for (int g = 1; g < 8; g++)
          if (f_sad(g, mj, seed) < bs) begin bs = f_sad(g, mj, seed); bg = g; end
        erv = 1; epart = mj; esad = bs;
        emx = f_mvx(bg, mj); emy = f_mvy(mj, seed);
        if (mj == 40) begin mstate = 0; edone = 1; end
        else begin mj++; mg = 0; end
      end else mg++;
    endcase
  endtask

  task automatic step(input bit s);
    start = s;
    @(posedge clk);
    advance(s);
    @(negedge clk);
    check_all();
  endtask

  task automatic run_search();
    step(1'b1);
    for (int i = 0; i < 3000 && mstate != 0; i++)
      step(i == 100 || i == 2100 || i == 2046);
    for (int i = 0; i < 3; i++) step(1'b0);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle state after reset
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(scan_valid == 0 && pos_done == 0, "R1 scan", {scan_valid, pos_done}, 0);
    chk(res_valid == 0, "R1 res_valid", res_valid, 0);
    rst_n = 1'b1;
    step(1'b0);
    seed = 0;
    run_search();
    seed = 3;
    run_search();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule